// File: doc/BRIEF.md
# PWM Clock Source Selector with Sync Lock and Fallback

This block decides which timebase starts each cycle of a switching regulator's PWM. By default a divider of the fast system clock acts as the internal oscillator. Its nominal rate is 750 kHz, which is 67 system clocks at 50 MHz. Each time the divider wraps, the block emits a one-cycle cycle-start strobe. An enable strobe can pause the divider for single system cycles.

An external sync pin may carry a clock between 500 kHz and 1 MHz. The pin is synchronized and edge-detected, and the block switches to it on the first rising edge it sees. From then on, cycle starts follow the accepted sync edges. While the external source is in use, an edge that arrives sooner than one minimum period (1 µs) after the previous cycle start is discarded as a double pulse.

The internal divider is re-phased on every accepted edge. It also counts the periods that pass without a sync edge. When four such periods elapse with no edge, the block returns to the internal source. The fourth wrap itself issues a cycle start, so the PWM keeps a strobe at the internal rate and sees no gap or short cycle. A flag output tells which source is active. With enable low, all outputs are held at zero.

Top module: `clk_src_sel`

## Requirements
- R1: While rst_n or en is low, start_o and ext_active_o are 0 in every cycle, and a sync edge during that time starts nothing. After en returns high, ext_active_o stays 0 (internal source).
- R2: With the internal source active and int_tick_en held high, start_o pulses for one cycle every OSC_DIV (default 67) system clocks.
- R3: Each system cycle in which int_tick_en is low lengthens the current internal period by one clock.
- R4: With the internal source active, the first sync rising edge sets start_o and ext_active_o together. This happens on the third system clock edge after the pin rises, and the strobe lasts one cycle.
- R5: While ext_active_o is 1, start_o follows each accepted sync edge, so strobe spacing equals the sync period (tested at 100 and 50 system clocks). Internal wraps issue no strobe in this mode.
- R6: While ext_active_o is 1, a sync edge whose strobe would come fewer than MIN_GAP (default 50) clocks after the previous strobe is ignored: no strobe, and ext_active_o stays 1.
- R7: If no sync edge is accepted for MISS_LIMIT (default 4) internal periods, ext_active_o falls. In that same cycle start_o pulses, exactly MISS_LIMIT*OSC_DIV (268) clocks after the last accepted edge's strobe. Internal strobes then follow every OSC_DIV clocks.
- R8: If a sync edge and an internal wrap fall in the same cycle, exactly one strobe is issued and the external source takes over.
- R9: A sync pin held high yields only one strobe: only rising edges count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; low forces idle |
| int_tick_en | input | 1 | Clock-enable strobe for the internal divider |
| sync_pin | input | 1 | Asynchronous external sync input |
| start_o | output | 1 | One-cycle PWM cycle-start strobe |
| ext_active_o | output | 1 | 1 when the external sync source is in use |

## Verification
Two functions can act in the same system cycle. One is an internal divider wrap, which is also the fallback timeout when the external source is in use. The other is acceptance of a synchronized sync edge. The bench times a sync pin rise so that its detected edge lands exactly on the cycle of the next internal wrap, counted from an observed strobe. It then requires a single strobe on that cycle, the external flag raised, and no strobe on the following cycle. The fallback is judged by measuring the exact clock distance from the last accepted edge to the strobe that coincides with the flag dropping.

// File: rtl/clk_src_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the PWM clock source selector.
// Assumes: nothing beyond IEEE 1800-2017.
package clk_src_pkg;
    // Which timebase currently drives cycle starts.
    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_mode_t;
endpackage

// File: rtl/clk_src_sync.sv
`timescale 1ns/1ps
// Module: clk_src_sync
// Brings the asynchronous sync pin into the clk domain through a flop chain
// and flags each rising edge as a one-cycle pulse.
// Assumes: STAGES >= 2; pin pulses are wider than one clk period.
module clk_src_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Metastability chain and previous-level flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    // Rising edge of the synchronized level.
    always_comb rise_o = chain_q[STAGES-1] & ~last_q;

    // A level that stays high must not produce a second edge pulse.
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R9
endmodule

// File: rtl/clk_src_osc.sv
`timescale 1ns/1ps
// Module: clk_src_osc
// Internal oscillator model: a divider of clk that advances on tick_en and
// reports a wrap every DIV advances. A restart request re-phases it to zero.
// Assumes: DIV >= 2; run_i low holds the count at zero.
module clk_src_osc #(
    parameter int DIV = 67
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_en_i,
    input  logic restart_i,
    output logic wrap_o
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Wrap happens on the advance that would leave the last count.
    always_comb wrap_o = run_i && tick_en_i && (cnt_q == LAST);

    // Divider count with restart and pause.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (restart_i || wrap_o) begin
            cnt_q <= '0;
        end else if (tick_en_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R2
endmodule

// File: rtl/clk_src_arb.sv
`timescale 1ns/1ps
// Module: clk_src_arb
// Source arbiter: picks internal wraps or accepted sync edges as cycle
// starts, blanks double pulses in external mode, counts missing periods
// and falls back to the internal source with a strobe on the timeout wrap.
// Assumes: MIN_GAP >= 2, MISS_LIMIT >= 1; wrap_i and rise_i are one-cycle.
module clk_src_arb
    import clk_src_pkg::*;
#(
    parameter int MIN_GAP    = 50,
    parameter int MISS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic rise_i,
    input  logic wrap_i,
    output logic accept_o,
    output logic start_o,
    output logic ext_o
);
    localparam int GW = $clog2(MIN_GAP + 1);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [GW-1:0] GAP_LIM  = GW'(MIN_GAP - 1);
    localparam logic [MW-1:0] MISS_TOP = MW'(MISS_LIMIT - 1);

    src_mode_t     mode_q;
    logic [GW-1:0] gap_q;
    logic [MW-1:0] miss_q;
    logic          start_q;
    logic          timeout;
    logic          start_d;

    // Decide this cycle's edge acceptance, timeout and strobe.
    always_comb begin
        accept_o = en_i && rise_i && ((mode_q == SRC_INT) || (gap_q >= GAP_LIM));
        timeout  = en_i && (mode_q == SRC_EXT) && wrap_i && !accept_o
                   && (miss_q == MISS_TOP);
        start_d  = accept_o || timeout || (en_i && (mode_q == SRC_INT) && wrap_i);
    end

    // Source mode register.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            mode_q <= SRC_INT;
        end else if (accept_o) begin
            mode_q <= SRC_EXT;
        end else if (timeout) begin
            mode_q <= SRC_INT;
        end
    end

    // Count of internal periods elapsed without an accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            miss_q <= '0;
        end else if (accept_o || timeout || (mode_q == SRC_INT)) begin
            miss_q <= '0;
        end else if (wrap_i) begin
            miss_q <= miss_q + 1'b1;
        end
    end

    // Saturating distance since the last strobe, for double-pulse blanking.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            gap_q <= '0;
        end else if (start_d) begin
            gap_q <= '0;
        end else if (gap_q < GAP_LIM) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Registered strobe output.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            start_q <= 1'b0;
        end else begin
            start_q <= start_d;
        end
    end

    always_comb begin
        start_o = start_q;
        ext_o   = (mode_q == SRC_EXT);
    end

    AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q <= MISS_TOP); // R7
endmodule

// File: rtl/clk_src_sel.sv
`timescale 1ns/1ps
// Module: clk_src_sel (top)
// PWM cycle-start source selector: internal divider by default, locks to
// the external sync pin on its first rising edge, falls back after
// MISS_LIMIT silent internal periods without losing a strobe.
// Assumes: clk is the fast system clock; sync_pin is asynchronous to it.
module clk_src_sel #(
    parameter int OSC_DIV     = 67,
    parameter int MIN_GAP     = 50,
    parameter int MISS_LIMIT  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic int_tick_en,
    input  logic sync_pin,
    output logic start_o,
    output logic ext_active_o
);
    logic sync_rise;
    logic osc_wrap;
    logic edge_accept;

    // Pin synchronizer and edge detector.
    clk_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (sync_pin),
        .rise_o (sync_rise)
    );

    // Internal oscillator divider, re-phased on accepted sync edges.
    clk_src_osc #(.DIV(OSC_DIV)) u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (en),
        .tick_en_i (int_tick_en),
        .restart_i (edge_accept),
        .wrap_o    (osc_wrap)
    );

    // Source arbitration and strobe generation.
    clk_src_arb #(.MIN_GAP(MIN_GAP), .MISS_LIMIT(MISS_LIMIT)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .rise_i   (sync_rise),
        .wrap_i   (osc_wrap),
        .accept_o (edge_accept),
        .start_o  (start_o),
        .ext_o    (ext_active_o)
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!start_o && !ext_active_o)); // R1
    AST_LOCK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_active_o) |-> start_o); // R4
    AST_FALLBACK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $fell(ext_active_o)) |-> start_o); // R7
endmodule

// File: tb/clk_src_sel_bench.sv
`timescale 1ns/1ps
// Directed bench for clk_src_sel; each task checks its own scenario.
module clk_src_sel_bench;
    localparam int DIV  = 67;
    localparam int GAP  = 50;
    localparam int MISS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic int_tick_en = 1'b1;
    logic sync_pin = 1'b0;
    logic start_o;
    logic ext_active_o;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int last_acc = 0;
    int last_w = 0;
    bit done = 1'b0;

    clk_src_sel #(.OSC_DIV(DIV), .MIN_GAP(GAP), .MISS_LIMIT(MISS)) u_clk_src_sel (
        .clk(clk), .rst_n(rst_n), .en(en), .int_tick_en(int_tick_en),
        .sync_pin(sync_pin), .start_o(start_o), .ext_active_o(ext_active_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Advance until start_o is seen; returns the cycle of the strobe.
    task automatic wait_start(input int maxc, output int at);
        at = -1;
        for (int i = 0; i < maxc; i++) begin
            step();
            if (start_o) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic t_reset();
        int hits = 0;
        for (int i = 0; i < 5; i++) begin
            step();
            hits += int'(start_o) + int'(ext_active_o);
        end
        check("R1 reset outputs", hits, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            hits += int'(start_o) + int'(ext_active_o);
        end
        check("R1 disabled outputs", hits, 0);
        @(negedge clk) en = 1'b1;
    endtask

    task automatic t_internal();
        int a, b;
        wait_start(DIV + 5, a);
        check("R2 first internal strobe seen", int'(a >= 0), 1);
        step();
        check("R2 strobe one cycle", int'(start_o), 0);
        for (int k = 0; k < 3; k++) begin
            wait_start(DIV + 5, b);
            check("R2 internal spacing", b - a, DIV);
            check("R2 internal flag", int'(ext_active_o), 0);
            a = b;
        end
        last_w = a;
    endtask

    task automatic t_pause();
        int b;
        repeat (5) step();
        @(negedge clk) int_tick_en = 1'b0;
        repeat (10) @(negedge clk);
        int_tick_en = 1'b1;
        wait_start(DIV + 20, b);
        check("R3 paused period", b - last_w, DIV + 10);
        last_w = b;
    endtask

    task automatic t_lock();
        int cnt = 0;
        repeat (20) step();
        check("R4 flag before lock", int'(ext_active_o), 0);
        @(negedge clk) sync_pin = 1'b1;
        step();
        step();
        check("R4 no early strobe", int'(start_o), 0);
        step();
        check("R4 lock strobe", int'(start_o), 1);
        check("R4 lock flag", int'(ext_active_o), 1);
        last_acc = cyc;
        for (int i = 0; i < 20; i++) begin
            step();
            cnt += int'(start_o);
        end
        check("R9 held high gives no extra strobe", cnt, 0);
        @(negedge clk) sync_pin = 1'b0;
    endtask

    task automatic t_ext_period(input int p);
        int extra = 0;
        while (cyc < last_acc + p - 3) begin
            step();
            extra += int'(start_o);
        end
        @(negedge clk) sync_pin = 1'b1;
        step();
        extra += int'(start_o);
        step();
        extra += int'(start_o);
        step();
        check("R5 no strobe between edges", extra, 0);
        check("R5 strobe on sync edge", int'(start_o), 1);
        check("R5 spacing equals sync period", cyc - last_acc, p);
        check("R5 flag held", int'(ext_active_o), 1);
        last_acc = cyc;
        @(negedge clk) sync_pin = 1'b0;
    endtask

    task automatic t_blank();
        int cnt = 0;
        while (cyc < last_acc + 6) step();
        @(negedge clk) sync_pin = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            cnt += int'(start_o);
        end
        check("R6 double pulse ignored", cnt, 0);
        check("R6 flag kept", int'(ext_active_o), 1);
        @(negedge clk) sync_pin = 1'b0;
    endtask

    task automatic t_timeout();
        int b, c;
        wait_start(400, b);
        check("R7 fallback delay", b - last_acc, MISS * DIV);
        check("R7 flag dropped with strobe", int'(ext_active_o), 0);
        wait_start(DIV + 5, c);
        check("R7 internal spacing resumes", c - b, DIV);
        last_w = c;
    endtask

    task automatic t_coincide();
        int extra = 0;
        while (cyc < last_w + DIV - 3) begin
            step();
            extra += int'(start_o);
        end
        @(negedge clk) sync_pin = 1'b1;
        step();
        extra += int'(start_o);
        step();
        extra += int'(start_o);
        step();
        check("R8 no strobe before coincidence", extra, 0);
        check("R8 single strobe at coincidence", int'(start_o), 1);
        check("R8 external taken", int'(ext_active_o), 1);
        step();
        check("R8 no second strobe", int'(start_o), 0);
        @(negedge clk) sync_pin = 1'b0;
    endtask

    task automatic t_disable();
        int hits = 0;
        int a, b;
        @(negedge clk) en = 1'b0;
        step();
        check("R1 disable clears flag", int'(ext_active_o), 0);
        @(negedge clk) sync_pin = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            hits += int'(start_o) + int'(ext_active_o);
        end
        @(negedge clk) sync_pin = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            hits += int'(start_o) + int'(ext_active_o);
        end
        check("R1 sync ignored while disabled", hits, 0);
        @(negedge clk) en = 1'b1;
        wait_start(DIV + 5, a);
        check("R1 internal after re-enable", int'(ext_active_o), 0);
        wait_start(DIV + 5, b);
        check("R1 re-enable spacing", b - a, DIV);
    endtask

    initial begin
        t_reset();
        t_internal();
        t_pause();
        t_lock();
        t_ext_period(100);
        t_ext_period(100);
        t_ext_period(50);
        t_blank();
        t_timeout();
        t_coincide();
        t_disable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule